// File: doc/BRIEF.md
# Leaf Page Entry Permission Check and Reference/Change Update

This block takes a 64-bit leaf entry of a radix translation tree and one requested access, which is a load, a store or an instruction fetch. It works out which of read, write and execute the access may use. The privilege of the requester, a scope flag (process-scoped or partition-scoped rules) and a permission mask taken from an access-mask register all feed into that result. If the access is refused, the block returns a small set of cause bits. Raising the interrupt is left to the logic that uses those bits.

If the access is allowed, the block sets the reference bit in the entry, and also the change bit when the access is a store. It then writes the entry back to memory through a valid/ready write port, but only if the value actually changed. A load or fetch has write permission removed from the permission set it reports. This forces a later store to come back through the check so that the change bit gets set.

The walker pulses `start` with the entry, the entry's address and the access attributes. It then waits for `done`. The result outputs stay constant until the next request.

Top module: `ptechk_rc`

## Requirements
- R1: When the attribute field (entry bits 5:4) equals 2'b10 (non-idempotent I/O) and the access is a fetch (`acc`=2), the block reports a fault with cause 3'b010, reports permission 3'b000 and performs no write. The same entry accessed by a load gets no guard fault.
- R2: Under process scope (`part_scope`=0), an entry with the privileged bit (bit 3) set, accessed in user mode, gets permission 3'b000, so every access to it faults.
- R3: Raw permissions come from entry bits 2, 1 and 0, with read = bit2|bit1, write = bit1 and execute = bit0. The permission order is {X,W,R}. They are used unmasked, and `amr_perm` is ignored, when the requester is in user mode, when the page is privileged, or when the scope is partition.
- R4: For a supervisor access to a non-privileged page under process scope, the raw permissions are ANDed with `amr_perm` ({X,W,R}).
- R5: When the permission needed by the access is missing (load needs R, store needs W, fetch needs X), `fault` is 1 and cause bit 0 is set. A store also sets cause bit 2. A faulting access reports permission 3'b000 and performs no write.
- R6: For an allowed access, the new entry is the old entry with bit 8 (reference) set. Bit 7 (change) is also set, but only for a store (`acc`=1).
- R7: For an allowed load or fetch, the reported permission has W cleared. For an allowed store, W is kept.
- R8: A write is issued only when the new entry differs from the old one. `done` pulses for one cycle. It comes one cycle after `start` when no write is issued, and one cycle after the handshake cycle (`wr_valid` and `wr_ready` both high) otherwise.
- R9: While `wr_valid` is high and `wr_ready` is low, `wr_valid`, `wr_addr` and `wr_data` hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken while not busy |
| pte | input | 64 | Leaf entry to check |
| pte_addr | input | AW | Memory address of the entry |
| acc | input | 2 | Access type: 0 load, 1 store, 2 fetch |
| user_mode | input | 1 | Requester is in user mode |
| part_scope | input | 1 | 1 selects partition-scoped rules |
| amr_perm | input | 3 | Mask-register permissions {X,W,R} |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Access refused |
| cause | output | 3 | {store, guard, protection} cause bits |
| perm | output | 3 | Granted permissions {X,W,R} |
| wr_valid | output | 1 | Write-back request |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | AW | Write-back address |
| wr_data | output | 64 | Updated entry |

## Verification
The hardest situation to reach is a write-back that memory stalls for several cycles. Only in that case is it visible whether the request fields hold steady and whether `done` follows the handshake rather than the request. The bench's memory model holds `wr_ready` low for a programmable number of cycles after `wr_valid` rises. Tests use zero delay and three cycles of delay, and check the latency of `done` against both. Entries that already carry the reference bit, and also the change bit when the access is a store, exercise the path on which no write is issued.

// File: rtl/ptechk_pkg.sv
package ptechk_pkg;
  localparam int PTE_W    = 64;
  localparam int BIT_REF  = 8;
  localparam int BIT_CHG  = 7;
  localparam int BIT_ATTH = 5;
  localparam int BIT_ATTL = 4;
  localparam int BIT_PRIV = 3;
  localparam int BIT_RD   = 2;
  localparam int BIT_RW   = 1;
  localparam int BIT_EX   = 0;
  localparam logic [1:0] ATT_NIO = 2'b10;

  typedef enum logic [1:0] {
    ACC_LOAD  = 2'd0,
    ACC_STORE = 2'd1,
    ACC_FETCH = 2'd2
  } acc_t;

  // permission vector order {X,W,R}
  localparam int P_R = 0;
  localparam int P_W = 1;
  localparam int P_X = 2;

  // cause vector order {store, guard, protection}
  localparam int C_PROT  = 0;
  localparam int C_GUARD = 1;
  localparam int C_STORE = 2;
endpackage

// File: rtl/ptechk_perm.sv
module ptechk_perm
  import ptechk_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  input  logic             user_mode,
  input  logic             part_scope,
  input  logic [2:0]       amr_perm,
  output logic [2:0]       perm_rep,
  output logic             fault,
  output logic [2:0]       cause
);
  logic [2:0] raw;
  logic [2:0] allowed;
  logic [2:0] need;
  logic       guard;
  logic       is_store;

  always_comb begin
    raw[P_R] = pte[BIT_RD] | pte[BIT_RW];
    raw[P_W] = pte[BIT_RW];
    raw[P_X] = pte[BIT_EX];

    if (!part_scope && pte[BIT_PRIV] && user_mode)
      allowed = 3'b000;
    else if (user_mode || pte[BIT_PRIV] || part_scope)
      allowed = raw;
    else
      allowed = raw & amr_perm;

    is_store = (acc == ACC_STORE);
    unique case (acc)
      ACC_LOAD:  need = 3'b001;
      ACC_STORE: need = 3'b010;
      default:   need = 3'b100;
    endcase

    guard = (pte[BIT_ATTH:BIT_ATTL] == ATT_NIO) && (acc == ACC_FETCH);

    cause = 3'b000;
    fault = 1'b0;
    if (guard) begin
      fault = 1'b1;
      cause[C_GUARD] = 1'b1;
    end else if ((need & ~allowed) != 3'b000) begin
      fault = 1'b1;
      cause[C_PROT]  = 1'b1;
      cause[C_STORE] = is_store;
    end

    if (fault)
      perm_rep = 3'b000;
    else if (is_store)
      perm_rep = allowed;
    else
      perm_rep = allowed & ~3'b010;
  end
endmodule

// File: rtl/ptechk_rcupd.sv
module ptechk_rcupd
  import ptechk_pkg::*;
(
  input  logic [PTE_W-1:0] pte,
  input  logic             is_store,
  output logic [PTE_W-1:0] npte,
  output logic             changed
);
  always_comb begin
    npte = pte;
    npte[BIT_REF] = 1'b1;
    if (is_store)
      npte[BIT_CHG] = 1'b1;
    changed = (npte != pte);
  end
endmodule

// File: rtl/ptechk_rc.sv
module ptechk_rc
  import ptechk_pkg::*;
#(
  parameter int AW = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [63:0]      pte,
  input  logic [AW-1:0]    pte_addr,
  input  logic [1:0]       acc,
  input  logic             user_mode,
  input  logic             part_scope,
  input  logic [2:0]       amr_perm,
  output logic             busy,
  output logic             done,
  output logic             fault,
  output logic [2:0]       cause,
  output logic [2:0]       perm,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic [AW-1:0]    wr_addr,
  output logic [63:0]      wr_data
);
  typedef enum logic {S_IDLE = 1'b0, S_WR = 1'b1} st_t;
  st_t st;

  logic [2:0]       perm_c;
  logic             fault_c;
  logic [2:0]       cause_c;
  logic [PTE_W-1:0] npte_c;
  logic             chg_c;

  ptechk_perm u_perm (
    .pte(pte), .acc(acc), .user_mode(user_mode), .part_scope(part_scope),
    .amr_perm(amr_perm), .perm_rep(perm_c), .fault(fault_c), .cause(cause_c)
  );

  ptechk_rcupd u_rc (
    .pte(pte), .is_store(acc == ACC_STORE), .npte(npte_c), .changed(chg_c)
  );

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      done     <= 1'b0;
      fault    <= 1'b0;
      cause    <= 3'b000;
      perm     <= 3'b000;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          fault <= fault_c;
          cause <= cause_c;
          perm  <= perm_c;
          if (!fault_c && chg_c) begin
            st       <= S_WR;
            wr_valid <= 1'b1;
            wr_addr  <= pte_addr;
            wr_data  <= npte_c;
          end else begin
            done <= 1'b1;
          end
        end
        default: if (wr_ready) begin
          wr_valid <= 1'b0;
          done     <= 1'b1;
          st       <= S_IDLE;
        end
      endcase
    end
  end

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data) && $stable(wr_addr)));

  assert_refset_R6: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> wr_data[BIT_REF]);

  assert_donepulse_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_faultquiet_R5: assert property (@(posedge clk) disable iff (rst)
    (done && fault) |-> (perm == 3'b000 && !wr_valid && cause != 3'b000));

  assert_doneidle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !wr_valid);
endmodule

// File: tb/ptechk_rc_tb.sv
module ptechk_rc_tb;
  localparam int AW = 48;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [63:0] pte = '0;
  logic [AW-1:0] pte_addr = '0;
  logic [1:0] acc = 2'd0;
  logic user_mode = 1'b0, part_scope = 1'b0;
  logic [2:0] amr_perm = 3'b000;
  logic busy, done, fault, wr_valid, wr_ready;
  logic [2:0] cause, perm;
  logic [AW-1:0] wr_addr;
  logic [63:0] wr_data;

  int checks = 0, fails = 0;
  int rdy_delay = 0, wait_cnt = 0;
  int wr_count = 0;
  logic [63:0] wr_seen;
  logic [AW-1:0] wr_seen_addr;

  always #4 clk = ~clk;

  ptechk_rc #(.AW(AW)) u_dut (
    .clk(clk), .rst(rst), .start(start), .pte(pte), .pte_addr(pte_addr),
    .acc(acc), .user_mode(user_mode), .part_scope(part_scope),
    .amr_perm(amr_perm), .busy(busy), .done(done), .fault(fault),
    .cause(cause), .perm(perm), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  assign wr_ready = wr_valid && (wait_cnt >= rdy_delay);

  always @(posedge clk) begin
    if (wr_valid && !wr_ready) wait_cnt <= wait_cnt + 1;
    else wait_cnt <= 0;
    if (wr_valid && wr_ready) begin
      wr_count <= wr_count + 1;
      wr_seen <= wr_data;
      wr_seen_addr <= wr_addr;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // runs one request; returns latency in cycles from start edge to done
  task automatic run(input logic [63:0] p, input logic [1:0] a, input logic um,
                     input logic ps, input logic [2:0] amr, input int dly,
                     output int lat, output int nwr);
    int w0;
    w0 = wr_count;
    rdy_delay = dly;
    @(negedge clk);
    pte = p; acc = a; user_mode = um; part_scope = ps; amr_perm = amr;
    pte_addr = 48'h0000_1234_5678;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 50) begin
      @(negedge clk);
      lat++;
    end
    nwr = wr_count - w0;
  endtask

  task automatic t_reset();
    chk("R8 reset done", {63'd0, done}, 64'd0);
    chk("R8 reset wr_valid", {63'd0, wr_valid}, 64'd0);
    chk("R5 reset fault", {63'd0, fault}, 64'd0);
  endtask

  task automatic t_guard();
    int lat, nw;
    run(64'h0000_0000_0000_0021, 2'd2, 1'b0, 1'b0, 3'b111, 0, lat, nw);
    chk("R1 guard fault", {63'd0, fault}, 64'd1);
    chk("R1 guard cause", {61'd0, cause}, 64'd2);
    chk("R1 guard perm", {61'd0, perm}, 64'd0);
    chk("R1 guard no write", nw, 0);
    run(64'h0000_0000_0000_0124, 2'd0, 1'b0, 1'b0, 3'b111, 0, lat, nw);
    chk("R1 io load not guarded", {63'd0, fault}, 64'd0);
    chk("R1 io load perm", {61'd0, perm}, 64'd1);
  endtask

  task automatic t_user_priv();
    int lat, nw;
    run(64'h0000_0000_0000_000F, 2'd0, 1'b1, 1'b0, 3'b111, 0, lat, nw);
    chk("R2 user priv fault", {63'd0, fault}, 64'd1);
    chk("R2 user priv cause", {61'd0, cause}, 64'd1);
    chk("R2 user priv perm", {61'd0, perm}, 64'd0);
    chk("R5 fault latency", lat, 1);
  endtask

  task automatic t_part_scope();
    int lat, nw;
    run(64'h0000_0000_0000_000A, 2'd0, 1'b1, 1'b1, 3'b000, 0, lat, nw);
    chk("R3 partition perm W removed", {61'd0, perm}, 64'd1);
    chk("R6 load write data", wr_seen, 64'h10A);
    chk("R8 write addr", {16'd0, wr_seen_addr}, 64'h0000_1234_5678);
    chk("R8 write latency", lat, 2);
    run(64'h0000_0000_0000_0004, 2'd0, 1'b1, 1'b0, 3'b000, 0, lat, nw);
    chk("R3 user amr ignored perm", {61'd0, perm}, 64'd1);
    chk("R3 user amr ignored fault", {63'd0, fault}, 64'd0);
  endtask

  task automatic t_amr();
    int lat, nw;
    run(64'h0000_0000_0000_0003, 2'd1, 1'b0, 1'b0, 3'b001, 0, lat, nw);
    chk("R4 amr denies store", {63'd0, fault}, 64'd1);
    chk("R5 store cause", {61'd0, cause}, 64'd5);
    chk("R5 no write on fault", nw, 0);
    run(64'h0000_0000_0000_0003, 2'd2, 1'b0, 1'b0, 3'b100, 0, lat, nw);
    chk("R4 amr masked fetch perm", {61'd0, perm}, 64'd4);
  endtask

  task automatic t_nowrite();
    int lat, nw;
    run(64'h0000_0000_0000_0183, 2'd1, 1'b0, 1'b0, 3'b111, 0, lat, nw);
    chk("R7 store keeps W", {61'd0, perm}, 64'd7);
    chk("R8 unchanged no write", nw, 0);
    chk("R8 unchanged latency", lat, 1);
    run(64'h0000_0000_0000_0103, 2'd0, 1'b0, 1'b0, 3'b111, 0, lat, nw);
    chk("R6 load no C set so no write", nw, 0);
    run(64'h0000_0000_0000_0103, 2'd2, 1'b0, 1'b0, 3'b111, 0, lat, nw);
    chk("R7 fetch drops W", {61'd0, perm}, 64'd5);
  endtask

  task automatic t_stall();
    int lat, nw;
    run(64'h0000_0000_0000_0003, 2'd1, 1'b0, 1'b0, 3'b111, 3, lat, nw);
    chk("R6 store sets R and C", wr_seen, 64'h183);
    chk("R9 stalled write count", nw, 1);
    chk("R8 stalled latency", lat, 5);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_guard();
    t_user_priv();
    t_part_scope();
    t_amr();
    t_nowrite();
    t_stall();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule